// File: doc/BRIEF.md
# Line-Locked PWM Clock Generator

This block makes a square-wave clock whose rate is a whole multiple of the incoming horizontal line rate. It runs on a fast free-running system clock. It watches an active-low line sync input and times the span between successive falling edges in system clocks. Over the next line it spreads a mode-chosen number of output periods evenly, using a fractional phase accumulator. The phase of the output restarts at every sync falling edge, so the first rising edge of each line keeps a fixed distance from sync. An external pulse-width modulator can use this clock and stay in step with the picture.

The output shares one pin with an overlay-tone signal. While the clock-enable bit is clear, which it is after reset, the pin is high inside a window region except where a character or graphic pixel is drawn. The pin lowers the gain of the video amplifiers to give a see-through window. When the enable bit is set, the pin carries the generated clock. The enable bit and the mode bit are sampled only at a sync falling edge, so a change never cuts a pulse short in mid-line.

No data stream passes through the block. Every pin is a plain level control or status signal, and there is no valid/ready handshake and no back-pressure.

Top module: `hsync_pwm_clkgen`

## Requirements
- R1: After reset, lock_valid is low and pwm_tone_pin follows the tone function, because the active clock-enable is cleared.
- R2: While the active clock-enable is 0, pwm_tone_pin equals win_active AND NOT pix_active in the same cycle.
- R3: lock_valid stays low until two sync falling edges have been seen. It rises only just after a falling edge that closes a valid line period.
- R4: With cfg_mode = 0 active and a steady line period, the pin shows exactly 32 rising edges per line.
- R5: With cfg_mode = 1 active and a steady line period, the pin shows exactly 48 rising edges per line.
- R6: While locked, the total high time per line is within N system clocks of half the line period (N = 32 or 48), and no half-period is shorter than two system clocks.
- R7: Each sync falling edge clears the phase accumulator and drives the clock level low. With equal line periods, the first rising edge falls at the same offset from sync on every line.
- R8: cfg_clk_en takes effect only at the next sync falling edge. In mid-line, changing it does not alter the pin.
- R9: cfg_mode takes effect only at the next sync falling edge. A line in progress keeps its rising-edge count.
- R10: If the counter saturates at 2^CNT_W-1 before the next falling edge, that period is treated as invalid. lock_valid then goes low and the clock output stays low.
- R11: A measured period shorter than 4*N_HI system clocks is invalid. lock_valid then goes low and the clock output stays low.
- R12: After an invalid period, lock_valid returns high at the first falling edge that closes a valid period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_n | input | 1 | Active-low horizontal line sync, asynchronous |
| cfg_clk_en | input | 1 | 1 selects the generated clock on the pin; 0 selects the tone signal |
| cfg_mode | input | 1 | 0 gives 32 output periods per line; 1 gives 48 |
| win_active | input | 1 | Current position lies inside a window region |
| pix_active | input | 1 | A character or graphic pixel is drawn at the current position |
| pwm_tone_pin | output | 1 | Shared pin: generated clock or tone level |
| lock_valid | output | 1 | Last measured line period is usable and the clock is running |

## Verification
The bench builds the block with CNT_W = 12 and keeps the default multiples of 32 and 48. With this width the counter saturates after about four thousand system clocks, so one long line is enough to test the overflow path in a short run. Line periods range from 400 to 1500 clocks, well above the 192-clock floor, so the rising-edge counts, the duty bound and the mid-line changes to enable and mode can all be checked against exact expected values. One 150-clock line tests the lower bound.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

  typedef enum logic {
    MODE_LOW  = 1'b0,
    MODE_HIGH = 1'b1
  } line_mode_e;

  // Phase increment per system clock: two toggles per output period.
  function automatic int unsigned step_for(input line_mode_e m,
                                           input int unsigned n_lo,
                                           input int unsigned n_hi);
    return (m == MODE_HIGH) ? 2 * n_hi : 2 * n_lo;
  endfunction

endpackage

// File: rtl/hpc_sync_edge.sv
module hpc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic fall
);
  localparam int LAST = STAGES;

  logic [LAST:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
    end else begin
      pipe_q <= {pipe_q[LAST-1:0], async_n};
    end
  end

  // Older sample high, newer sample low: one falling edge.
  assign fall = pipe_q[LAST] & ~pipe_q[LAST-1];

endmodule

// File: rtl/hpc_line_meter.sv
module hpc_line_meter #(
  parameter int CNT_W      = 16,
  parameter int MIN_PERIOD = 192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall,
  output logic [CNT_W-1:0] period_q,
  output logic             lock_q
);
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_PERIOD);

  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;
  logic             full;
  logic [CNT_W-1:0] span;
  logic             span_ok;

  assign full    = &cnt_q;
  assign span    = cnt_q + 1'b1;
  assign span_ok = seen_q && !full && (span >= FLOOR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (fall) begin
      cnt_q <= '0;
    end else if (!full) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q   <= 1'b0;
      lock_q   <= 1'b0;
      period_q <= '0;
    end else if (fall) begin
      seen_q <= 1'b1;
      lock_q <= span_ok;
      if (span_ok) begin
        period_q <= span;
      end
    end
  end

endmodule

// File: rtl/hpc_phase_acc.sv
module hpc_phase_acc
  import hpc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_LO  = 32,
  parameter int N_HI  = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall,
  input  logic             lock,
  input  line_mode_e       mode,
  input  logic [CNT_W-1:0] period,
  output logic             clk_q,
  output logic             acc_zero
);
  localparam int ACC_W = CNT_W + 1;
  localparam logic [ACC_W-1:0] STEP_LO = ACC_W'(2 * N_LO);
  localparam logic [ACC_W-1:0] STEP_HI = ACC_W'(2 * N_HI);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] per_ext;
  logic             wrap;

  assign step    = (mode == MODE_HIGH) ? STEP_HI : STEP_LO;
  assign sum     = acc_q + step;
  assign per_ext = {1'b0, period};
  assign wrap    = (sum >= per_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      clk_q <= 1'b0;
    end else if (fall || !lock) begin
      acc_q <= '0;
      clk_q <= 1'b0;
    end else if (wrap) begin
      acc_q <= sum - per_ext;
      clk_q <= ~clk_q;
    end else begin
      acc_q <= sum;
    end
  end

  assign acc_zero = (acc_q == '0);

endmodule

// File: rtl/hsync_pwm_clkgen.sv
module hsync_pwm_clkgen
  import hpc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int N_LO        = 32,
  parameter int N_HI        = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_n,
  input  logic cfg_clk_en,
  input  logic cfg_mode,
  input  logic win_active,
  input  logic pix_active,
  output logic pwm_tone_pin,
  output logic lock_valid
);
  localparam int MIN_PERIOD = 4 * N_HI;

  logic             fall_evt;
  logic [CNT_W-1:0] period_q;
  logic             act_en;
  line_mode_e       act_mode;
  logic             clk_q;
  logic             acc_zero;
  logic             tone;

  hpc_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_n (hsync_n),
    .fall    (fall_evt)
  );

  hpc_line_meter #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD)) u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall     (fall_evt),
    .period_q (period_q),
    .lock_q   (lock_valid)
  );

  // Configuration is taken only at line start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_en   <= 1'b0;
      act_mode <= MODE_LOW;
    end else if (fall_evt) begin
      act_en   <= cfg_clk_en;
      act_mode <= line_mode_e'(cfg_mode);
    end
  end

  hpc_phase_acc #(.CNT_W(CNT_W), .N_LO(N_LO), .N_HI(N_HI)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall     (fall_evt),
    .lock     (lock_valid),
    .mode     (act_mode),
    .period   (period_q),
    .clk_q    (clk_q),
    .acc_zero (acc_zero)
  );

  assign tone         = win_active & ~pix_active;
  assign pwm_tone_pin = act_en ? clk_q : tone;

endmodule

// File: rtl/hpc_checker.sv
module hpc_checker #(
  parameter int CNT_W      = 16,
  parameter int MIN_PERIOD = 192
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fall_evt,
  input logic             act_en,
  input logic             act_mode,
  input logic             lock_valid,
  input logic             clk_q,
  input logic             acc_zero,
  input logic [CNT_W-1:0] period_q
);
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_PERIOD);

  // R3
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_valid) |-> $past(fall_evt));

  // R7
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> (!clk_q && acc_zero));

  // R8
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(act_en));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(act_mode));

  // R10
  unlocked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_valid |=> !clk_q);

  // R11
  period_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_valid |-> (period_q >= FLOOR));

  // R6
  min_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_valid && $past(lock_valid) && !$past(fall_evt) && !$past(fall_evt, 2)
     && (clk_q != $past(clk_q))) |-> ($past(clk_q) == $past(clk_q, 2)));

endmodule

bind hsync_pwm_clkgen hpc_checker #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fall_evt   (fall_evt),
  .act_en     (act_en),
  .act_mode   (act_mode),
  .lock_valid (lock_valid),
  .clk_q      (clk_q),
  .acc_zero   (acc_zero),
  .period_q   (period_q)
);

// File: tb/hsync_pwm_clkgen_test.sv
`timescale 1ns/1ps
module hsync_pwm_clkgen_test;
  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_n = 1'b1;
  logic cfg_clk_en = 1'b0;
  logic cfg_mode = 1'b0;
  logic win_active = 1'b0;
  logic pix_active = 1'b0;
  logic pwm_tone_pin;
  logic lock_valid;

  int tests = 0;
  int fails = 0;
  bit last_pin = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hsync_pwm_clkgen #(.CNT_W(CNT_W)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .hsync_n      (hsync_n),
    .cfg_clk_en   (cfg_clk_en),
    .cfg_mode     (cfg_mode),
    .win_active   (win_active),
    .pix_active   (pix_active),
    .pwm_tone_pin (pwm_tone_pin),
    .lock_valid   (lock_valid)
  );

  function automatic int exp_edges(input bit mode);
    return mode ? 48 : 32;
  endfunction

  function automatic bit tone_of(input bit w, input bit p);
    return w & ~p;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One line of p system clocks; sync low for the first 4 clocks.
  task automatic run_line(input int p, input int chg_at, input bit new_en, input bit new_mode,
                          output int rises, output int highs, output int late_highs,
                          output int first_rise);
    rises = 0; highs = 0; late_highs = 0; first_rise = -1;
    for (int c = 0; c < p; c++) begin
      @(negedge clk);
      if (pwm_tone_pin && !last_pin) begin
        rises++;
        if (first_rise < 0) first_rise = c;
      end
      if (pwm_tone_pin) begin
        highs++;
        if (c >= 8) late_highs++;
      end
      last_pin = pwm_tone_pin;
      hsync_n = (c < 4) ? 1'b0 : 1'b1;
      if (c == chg_at) begin
        cfg_clk_en = new_en;
        cfg_mode   = new_mode;
      end
    end
  endtask

  // Three lines of period p; mode applied during the first line.
  task automatic run_group(input int p, input bit mode);
    int r, h, lh, fr, fr_prev;
    fr_prev = -1;
    for (int l = 0; l < 3; l++) begin
      run_line(p, (l == 0) ? 10 : -1, 1'b1, mode, r, h, lh, fr);
      if (l >= 1) begin
        if (mode) check(r == 48, "R5 edges per line", r, 48);
        else      check(r == 32, "R4 edges per line", r, 32);
        check(iabs(2 * h - p) <= 2 * exp_edges(mode), "R6 high time", 2 * h, p);
      end
      if (l == 2) check(fr == fr_prev, "R7 first edge offset", fr, fr_prev);
      fr_prev = fr;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int r, h, lh, fr;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(lock_valid == 1'b0, "R1 lock after reset", lock_valid, 0);
    win_active = 1'b1; pix_active = 1'b0; #1;
    check(pwm_tone_pin == 1'b1, "R1 tone after reset", pwm_tone_pin, 1);

    // R2: random window/pixel patterns
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      win_active = 1'($urandom_range(0, 1));
      pix_active = 1'($urandom_range(0, 1));
      #1;
      check(pwm_tone_pin == tone_of(win_active, pix_active), "R2 tone level",
            pwm_tone_pin, tone_of(win_active, pix_active));
    end
    win_active = 1'b0; pix_active = 1'b0;

    // R3: lock needs two falling edges
    cfg_clk_en = 1'b1; cfg_mode = 1'b0;
    run_line(640, -1, 1'b1, 1'b0, r, h, lh, fr);
    check(lock_valid == 1'b0, "R3 lock after one edge", lock_valid, 0);
    check(lh == 0, "R10 pin low while unlocked", lh, 0);
    run_line(640, -1, 1'b1, 1'b0, r, h, lh, fr);
    check(lock_valid == 1'b1, "R3 lock after two edges", lock_valid, 1);
    check(r == 32, "R4 edges first locked line", r, 32);

    run_group(640, 1'b0);
    run_group(960, 1'b1);
    for (int g = 0; g < 6; g++) begin
      run_group(400 + int'($urandom_range(0, 1100)), 1'($urandom_range(0, 1)));
    end

    // R9: mode change mid-line waits for the next edge
    run_group(960, 1'b1);
    run_line(960, 300, 1'b1, 1'b0, r, h, lh, fr);
    check(r == 48, "R9 mode held mid-line", r, 48);
    run_line(960, -1, 1'b1, 1'b0, r, h, lh, fr);
    check(r == 32, "R9 mode applied next line", r, 32);

    // R8: enable changes wait for the next edge
    win_active = 1'b1; pix_active = 1'b0;
    run_line(960, 100, 1'b0, 1'b0, r, h, lh, fr);
    check(r == 32, "R8 clock kept after disable", r, 32);
    run_line(960, 480, 1'b1, 1'b0, r, h, lh, fr);
    check(lh == 960 - 8, "R8 tone kept after enable", lh, 960 - 8);
    run_line(960, -1, 1'b1, 1'b0, r, h, lh, fr);
    check(r == 32, "R8 clock after next edge", r, 32);
    win_active = 1'b0;

    // R10: counter saturation
    run_line(5000, -1, 1'b1, 1'b0, r, h, lh, fr);
    run_line(960, -1, 1'b1, 1'b0, r, h, lh, fr);
    check(lock_valid == 1'b0, "R10 lock after overlong line", lock_valid, 0);
    check(lh == 0, "R10 pin low after overlong line", lh, 0);
    run_line(960, -1, 1'b1, 1'b0, r, h, lh, fr);
    check(lock_valid == 1'b1, "R12 relock after overlong line", lock_valid, 1);
    run_line(960, -1, 1'b1, 1'b0, r, h, lh, fr);
    check(r == 32, "R12 edges after relock", r, 32);

    // R11: too-short line
    run_line(150, -1, 1'b1, 1'b0, r, h, lh, fr);
    run_line(960, -1, 1'b1, 1'b0, r, h, lh, fr);
    check(lock_valid == 1'b0, "R11 lock after short line", lock_valid, 0);
    check(lh == 0, "R11 pin low after short line", lh, 0);
    run_line(960, -1, 1'b1, 1'b0, r, h, lh, fr);
    check(lock_valid == 1'b1, "R12 relock after short line", lock_valid, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule